// File: doc/BRIEF.md
# Masked GPIO Port Register Bank

This block is the register side of a general-purpose I/O port. A simple register bus (write strobe, read strobe, word address, write data, read data) controls per-pin direction bits and an output latch, which drive the pad output-enable and output-value lines. The pad input levels go through a two-flop synchronizer. All register reads see only the synchronized levels.

Software can change the output latch in several ways. It can write one pin through that pin's own register. It can set, clear or invert any group of pins atomically with a write-one register. It can also write the whole port through a masked port register, where a mask chooses which pins the write touches. Reads return the whole port level, a single pin's level, or the masked port level. Excluded pins read as zero.

Address map for the default 32 pins: pin n's own register is at word n (0x00 to 0x1F). The control registers are at 0x20 + k, where k is 0 DIR, 1 LEVEL, 2 MASK, 3 MPORT, 4 SET, 5 CLR and 6 FLIP. Word 0x27 is unused.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every direction bit, output latch bit and mask bit is 0. Reads of DIR and MASK return 0.
- R2: A write to DIR (0x20) sets pad_oe_o to the written bits on the next cycle, where 1 means output. A read of DIR returns those bits.
- R3: A write to pin register n (word n) sets output latch bit n to write-data bit 0. All other latch bits are left unchanged.
- R4: A read of pin register n returns pin n's synchronized pad level in bit 0, with all other bits 0.
- R5: A write to SET (0x24) drives to 1 every latch bit whose data bit is 1. All other bits are left unchanged.
- R6: A write to CLR (0x25) drives to 0 every latch bit whose data bit is 1. All other bits are left unchanged.
- R7: A write to FLIP (0x26) inverts every latch bit whose data bit is 1.
- R8: MASK (0x22) is read/write. A write to MPORT (0x23) updates only the latch bits whose mask bit is 0.
- R9: A read of MPORT returns the synchronized level on pins whose mask bit is 0. Pins with mask bit 1 read as 0.
- R10: A read of LEVEL (0x21) returns the whole port's synchronized pad level, for output pins as well as input pins. A pad change is not visible to a read issued in the cycle right after the change. It is visible to a read issued three cycles later.
- R11: Read data appears one cycle after the read strobe and holds until the next read. Writes in consecutive cycles to different registers both take effect, in issue order.
- R12: Writes to the unused word 0x27 change nothing, and reads of it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W (6) | Word address |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, one cycle after rd_en_i |
| pad_in_i | input | NPINS (32) | Raw pad input levels |
| pad_oe_o | output | NPINS (32) | Pad output enables (direction bits) |
| pad_out_o | output | NPINS (32) | Output latch driven to pads |

## Verification
The latch write paths run in a chain from one known latch value to the next. The data words mix bits that are already 1, already 0, and inside and outside the mask. This separates set from clear from invert, and it shows a masked write that leaks onto excluded pins. The read paths are tried on an asymmetric pad pattern, so a wrong pin index, a mask that is not inverted, or a latch value returned in place of the pad level each gives a different word. Back-to-back writes in opposite orders show whether both take effect in sequence. A read issued at once after a pad change shows whether the synchronizer has both stages.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // control register offset, low address bits within the upper half of the map
  typedef enum logic [2:0] {
    CR_DIR   = 3'd0,
    CR_LEVEL = 3'd1,
    CR_MASK  = 3'd2,
    CR_MPORT = 3'd3,
    CR_SET   = 3'd4,
    CR_CLR   = 3'd5,
    CR_FLIP  = 3'd6,
    CR_NONE  = 3'd7
  } ctrl_reg_e;

  localparam int unsigned MIN_PIN_AW = 4;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/gpio_bank_dec.sv
module gpio_bank_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned PIN_AW = 5,
  parameter int unsigned ADDR_W = PIN_AW + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pin_hit_o,
  output logic [PIN_AW-1:0] pin_idx_o,
  output ctrl_reg_e         ctrl_o
);
  logic upper;
  logic mid_zero;

  assign upper     = addr_i[ADDR_W-1];
  assign pin_idx_o = addr_i[PIN_AW-1:0];
  assign mid_zero  = (addr_i[ADDR_W-2:3] == '0);
  assign pin_hit_o = !upper && ({1'b0, pin_idx_o} < (PIN_AW+1)'(NPINS));

  always_comb begin
    ctrl_o = CR_NONE;
    if (upper && mid_zero) ctrl_o = ctrl_reg_e'(addr_i[2:0]);
  end
endmodule

// File: rtl/gpio_bank_wr.sv
module gpio_bank_wr
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned PIN_AW = 5
) (
  input  logic              wr_en_i,
  input  logic              pin_hit_i,
  input  logic [PIN_AW-1:0] pin_idx_i,
  input  ctrl_reg_e         ctrl_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  out_q_i,
  input  logic [NPINS-1:0]  dir_q_i,
  input  logic [NPINS-1:0]  mask_q_i,
  output logic [NPINS-1:0]  out_d_o,
  output logic [NPINS-1:0]  dir_d_o,
  output logic [NPINS-1:0]  mask_d_o
);
  always_comb begin
    out_d_o  = out_q_i;
    dir_d_o  = dir_q_i;
    mask_d_o = mask_q_i;
    if (wr_en_i) begin
      if (pin_hit_i) begin
        for (int i = 0; i < NPINS; i++)
          if (pin_idx_i == PIN_AW'(i)) out_d_o[i] = wdata_i[0];
      end else begin
        case (ctrl_i)
          CR_DIR:   dir_d_o  = wdata_i;
          CR_MASK:  mask_d_o = wdata_i;
          CR_MPORT: out_d_o  = (out_q_i & mask_q_i) | (wdata_i & ~mask_q_i);
          CR_SET:   out_d_o  = out_q_i | wdata_i;
          CR_CLR:   out_d_o  = out_q_i & ~wdata_i;
          CR_FLIP:  out_d_o  = out_q_i ^ wdata_i;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_bank_rd.sv
module gpio_bank_rd
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned PIN_AW = 5
) (
  input  logic              pin_hit_i,
  input  logic [PIN_AW-1:0] pin_idx_i,
  input  ctrl_reg_e         ctrl_i,
  input  logic [NPINS-1:0]  lvl_i,
  input  logic [NPINS-1:0]  dir_i,
  input  logic [NPINS-1:0]  mask_i,
  output logic [DW-1:0]     rd_d_o
);
  always_comb begin
    rd_d_o = '0;
    if (pin_hit_i) begin
      for (int i = 0; i < NPINS; i++)
        if (pin_idx_i == PIN_AW'(i)) rd_d_o = DW'(lvl_i[i]);
    end else begin
      case (ctrl_i)
        CR_DIR:   rd_d_o = DW'(dir_i);
        CR_LEVEL: rd_d_o = DW'(lvl_i);
        CR_MASK:  rd_d_o = DW'(mask_i);
        CR_MPORT: rd_d_o = DW'(lvl_i & ~mask_i);
        default:  rd_d_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter  int unsigned NPINS  = 32,
  parameter  int unsigned DW     = 32,
  localparam int unsigned PIN_AW = ($clog2(NPINS) > MIN_PIN_AW) ? $clog2(NPINS) : MIN_PIN_AW,
  localparam int unsigned ADDR_W = PIN_AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_out_o
);
  logic              pin_hit;
  logic [PIN_AW-1:0] pin_idx;
  ctrl_reg_e         ctrl;
  logic [NPINS-1:0]  lvl;
  logic [NPINS-1:0]  out_q, out_d, dir_q, dir_d, mask_q, mask_d;
  logic [DW-1:0]     rd_d;

  gpio_bank_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pad_in_i), .q_o (lvl)
  );

  gpio_bank_dec #(.NPINS(NPINS), .PIN_AW(PIN_AW), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i), .pin_hit_o (pin_hit), .pin_idx_o (pin_idx), .ctrl_o (ctrl)
  );

  gpio_bank_wr #(.NPINS(NPINS), .PIN_AW(PIN_AW)) u_wr (
    .wr_en_i   (wr_en_i),
    .pin_hit_i (pin_hit),
    .pin_idx_i (pin_idx),
    .ctrl_i    (ctrl),
    .wdata_i   (wdata_i[NPINS-1:0]),
    .out_q_i   (out_q),
    .dir_q_i   (dir_q),
    .mask_q_i  (mask_q),
    .out_d_o   (out_d),
    .dir_d_o   (dir_d),
    .mask_d_o  (mask_d)
  );

  gpio_bank_rd #(.NPINS(NPINS), .DW(DW), .PIN_AW(PIN_AW)) u_rd (
    .pin_hit_i (pin_hit),
    .pin_idx_i (pin_idx),
    .ctrl_i    (ctrl),
    .lvl_i     (lvl),
    .dir_i     (dir_q),
    .mask_i    (mask_q),
    .rd_d_o    (rd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      mask_q  <= '0;
      rdata_o <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      mask_q <= mask_d;
      if (rd_en_i) rdata_o <= rd_d;
    end
  end

  assign pad_oe_o  = dir_q;
  assign pad_out_o = out_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [NPINS-1:0]  pad_oe_o,
  input logic [NPINS-1:0]  pad_out_o,
  input logic [NPINS-1:0]  mask_q
);
  localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] A_DIR  = BASE + ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MPRT = BASE + ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SET  = BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLR  = BASE + ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FLIP = BASE + ADDR_W'(6);

  logic [NPINS-1:0] wd;
  assign wd = wdata_i[NPINS-1:0];

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_clear_R1: assert (pad_oe_o == '0 && pad_out_o == '0 && mask_q == '0);

  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DIR) |=> (pad_oe_o == $past(wd)));

  assert_set_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_SET) |=> (pad_out_o == ($past(pad_out_o) | $past(wd))));

  assert_clr_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CLR) |=> ((pad_out_o & $past(wd)) == '0));

  assert_flip_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_FLIP) |=> (pad_out_o == ($past(pad_out_o) ^ $past(wd))));

  assert_masked_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_MPRT) |=>
      (pad_out_o == (($past(pad_out_o) & $past(mask_q)) | ($past(wd) & ~$past(mask_q)))));

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pad_out_o) && $stable(pad_oe_o) && $stable(mask_q)));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .pad_oe_o  (pad_oe_o),
  .pad_out_o (pad_out_o),
  .mask_q    (mask_q)
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  localparam int AW = 6;
  localparam logic [AW-1:0] A_DIR = 6'h20, A_LVL = 6'h21, A_MSK = 6'h22, A_MPT = 6'h23,
                            A_SET = 6'h24, A_CLR = 6'h25, A_FLP = 6'h26, A_UNU = 6'h27;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, pad_in_i = '0, pad_oe_o, pad_out_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_bank u_dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_en_i (wr_en_i), .rd_en_i (rd_en_i),
    .addr_i (addr_i), .wdata_i (wdata_i), .rdata_o (rdata_o),
    .pad_in_i (pad_in_i), .pad_oe_o (pad_oe_o), .pad_out_o (pad_out_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 oe in reset", pad_oe_o, 32'h0);
    chk("R1 out in reset", pad_out_o, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(A_DIR, v); chk("R1 dir read", v, 32'h0);
    rd(A_MSK, v); chk("R1 mask read", v, 32'h0);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(A_DIR, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe_o, 32'hA5A5_0F0F);
    rd(A_DIR, v); chk("R2 dir read", v, 32'hA5A5_0F0F);
  endtask

  task automatic t_pin_write();
    wr(6'd5, 32'hFFFF_FFFF);  chk("R3 pin5 set", pad_out_o, 32'h0000_0020);
    wr(6'd31, 32'h0000_0002); chk("R3 only bit0 used", pad_out_o, 32'h0000_0020);
    wr(6'd31, 32'h0000_0001); chk("R3 pin31 set", pad_out_o, 32'h8000_0020);
    wr(6'd5, 32'h0000_0000);  chk("R3 pin5 clear", pad_out_o, 32'h8000_0000);
  endtask

  task automatic t_set_clr_flip();
    wr(A_SET, 32'h0000_00FF); chk("R5 set", pad_out_o, 32'h8000_00FF);
    wr(A_CLR, 32'h8000_000F); chk("R6 clr", pad_out_o, 32'h0000_00F0);
    wr(A_FLP, 32'hFF00_00FF); chk("R7 flip", pad_out_o, 32'hFF00_000F);
  endtask

  task automatic t_masked();
    logic [31:0] v;
    wr(A_MSK, 32'hFFFF_0000);
    rd(A_MSK, v); chk("R8 mask read", v, 32'hFFFF_0000);
    wr(A_MPT, 32'h1234_5678); chk("R8 masked write", pad_out_o, 32'hFF00_5678);
    wr(A_MSK, 32'h0000_0000);
    wr(A_MPT, 32'hDEAD_BEEF); chk("R8 open mask write", pad_out_o, 32'hDEAD_BEEF);
  endtask

  task automatic t_reads();
    logic [31:0] v;
    wr(A_DIR, 32'hFFFF_FFFF);
    pad_in_i = 32'h0F0F_3C3C;
    repeat (3) @(negedge clk_i);
    rd(A_LVL, v); chk("R10 level read on outputs", v, 32'h0F0F_3C3C);
    rd(6'd2, v);  chk("R4 pin2", v, 32'h1);
    rd(6'd0, v);  chk("R4 pin0", v, 32'h0);
    rd(6'd27, v); chk("R4 pin27", v, 32'h1);
    rd(6'd28, v); chk("R4 pin28", v, 32'h0);
    wr(A_MSK, 32'h00FF_00FF);
    rd(A_MPT, v); chk("R9 masked read", v, 32'h0F00_3C00);
    wr(A_MSK, 32'h0000_0000);
  endtask

  task automatic t_sync();
    logic [31:0] v;
    @(negedge clk_i);
    pad_in_i = 32'hFFFF_0000;
    rd(A_LVL, v); chk("R10 change not yet visible", v, 32'h0F0F_3C3C);
    repeat (2) @(negedge clk_i);
    rd(A_LVL, v); chk("R10 change visible", v, 32'hFFFF_0000);
    repeat (3) @(negedge clk_i);
    chk("R11 read data held", rdata_o, 32'hFFFF_0000);
  endtask

  task automatic t_back_to_back();
    logic [31:0] v;
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = A_CLR; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i);
    addr_i = A_SET; wdata_i = 32'h0000_0003;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R11 clr then set", pad_out_o, 32'h0000_0003);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 6'd4; wdata_i = 32'h1;
    @(negedge clk_i);
    addr_i = A_FLP; wdata_i = 32'h0000_0011;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R11 pin write then flip", pad_out_o, 32'h0000_0002);
    wr(A_UNU, 32'hFFFF_FFFF);
    chk("R12 unused write out", pad_out_o, 32'h0000_0002);
    chk("R12 unused write oe", pad_oe_o, 32'hFFFF_FFFF);
    rd(A_MSK, v); chk("R12 unused write mask", v, 32'h0);
    rd(A_UNU, v); chk("R12 unused read", v, 32'h0);
  endtask

  initial begin
    t_reset();
    t_dir();
    t_pin_write();
    t_set_clr_flip();
    t_masked();
    t_reads();
    t_sync();
    t_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule